// File: doc/BRIEF.md
# Condition Code Evaluation Unit

This block decides whether a conditionally executed instruction is allowed to take effect. It takes a 4-bit condition selector and the four status flags: negative (N), zero (Z), carry (C) and signed overflow (V). It raises a single pass indication when the selected test holds. Fifteen selector values are defined: fourteen flag tests plus an unconditional one. The sixteenth value is reported as undefined and never passes.

The block also sits between the decoder and the write-back stage. It takes the instruction's three side-effect requests: register write, status-flag write and branch. Each request leaves the block only when the condition passes. An instruction whose condition fails therefore behaves as a no-operation.

The unit is purely combinational. Its outputs follow its inputs within the same cycle, with no register on the path.

Top module: `ccu_eval_top`

## Requirements
- R1: Selector 4'b0000 passes exactly when Z is 1, and selector 4'b0001 passes exactly when Z is 0.
- R2: Selector 4'b0010 passes exactly when C is 1, and selector 4'b0011 passes exactly when C is 0.
- R3: Selector 4'b0100 passes when N is 1 and 4'b0101 when N is 0. Selector 4'b0110 passes when V is 1 and 4'b0111 when V is 0.
- R4: Selector 4'b1000 passes exactly when C is 1 and Z is 0. Selector 4'b1001 passes exactly when C is 0 or Z is 1.
- R5: Selector 4'b1010 passes exactly when N equals V, and selector 4'b1011 passes exactly when N differs from V.
- R6: Selector 4'b1100 passes exactly when Z is 0 and N equals V. Selector 4'b1101 passes exactly when Z is 1 or N differs from V.
- R7: Selector 4'b1110 passes for every combination of the four flags.
- R8: Selector 4'b1111 drives pass low and the undefined output high for every flag combination. For every other selector value the undefined output is low.
- R9: When the condition passes, each of the three gated outputs (register write, flag write, branch) equals its own request input.
- R10: When the condition fails, all three gated outputs are 0, whatever their requests are.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| cond_i | input | 4 | Condition selector carried by the instruction |
| flag_n_i | input | 1 | Negative flag |
| flag_z_i | input | 1 | Zero flag |
| flag_c_i | input | 1 | Carry flag |
| flag_v_i | input | 1 | Signed overflow flag |
| reg_we_i | input | 1 | Register write request |
| flag_we_i | input | 1 | Status-flag write request |
| branch_req_i | input | 1 | Branch request |
| pass_o | output | 1 | Condition holds; instruction may execute |
| undef_o | output | 1 | Selector value 4'b1111 seen |
| reg_we_o | output | 1 | Register write request after gating |
| flag_we_o | output | 1 | Status-flag write request after gating |
| branch_o | output | 1 | Branch request after gating |

## Verification
The unit holds no state, so any decode fault appears on pass_o, and on every gated request, in the same cycle as the offending selector and flag pattern. A fault shows up only under the flag combinations where the faulty and the correct test disagree. For that reason each selector is driven with all sixteen flag patterns. A fault that swaps a pair polarity, or that merges the two compound signed tests, will flip pass_o for at least one of those patterns. The gating stage is checked under both outcomes of the condition, with all eight request patterns.

// File: rtl/ccu_pkg.sv
package ccu_pkg;

    localparam int COND_W    = 4;
    localparam int GROUP_W   = COND_W - 1;
    localparam int NUM_GROUP = 1 << GROUP_W;
    localparam int NUM_SIDE  = 3;

    // Group index = upper three selector bits; the low bit picks the inverse.
    typedef enum logic [GROUP_W-1:0] {
        GRP_ZERO    = 3'd0,
        GRP_CARRY   = 3'd1,
        GRP_NEG     = 3'd2,
        GRP_OVF     = 3'd3,
        GRP_UHI     = 3'd4,
        GRP_SGE     = 3'd5,
        GRP_SGT     = 3'd6,
        GRP_UNCOND  = 3'd7
    } cond_group_e;

    typedef struct packed {
        logic n;
        logic z;
        logic c;
        logic v;
    } status_flags_t;

    typedef struct packed {
        logic pass;
        logic undef;
    } verdict_t;

endpackage

// File: rtl/ccu_flag_terms.sv
module ccu_flag_terms
    import ccu_pkg::*;
(
    input  status_flags_t          flags_i,
    output logic [NUM_GROUP-1:0]   terms_o
);

    logic [NUM_GROUP-1:0] terms_d;

    always_comb begin
        terms_d             = '0;
        terms_d[GRP_ZERO]   = flags_i.z;
        terms_d[GRP_CARRY]  = flags_i.c;
        terms_d[GRP_NEG]    = flags_i.n;
        terms_d[GRP_OVF]    = flags_i.v;
        terms_d[GRP_UHI]    = flags_i.c & ~flags_i.z;
        terms_d[GRP_SGE]    = ~(flags_i.n ^ flags_i.v);
        terms_d[GRP_SGT]    = ~flags_i.z & ~(flags_i.n ^ flags_i.v);
        terms_d[GRP_UNCOND] = 1'b1;
    end

    assign terms_o = terms_d;

    always_comb begin
        if (terms_o[GRP_SGT]) assert (terms_o[GRP_SGE] && !flags_i.z)
            else $error("AST_SGT_IMPLIES_SGE");  // R6
        if (terms_o[GRP_UHI]) assert (terms_o[GRP_CARRY])
            else $error("AST_UHI_NEEDS_CARRY");  // R4
    end

endmodule

// File: rtl/ccu_cond_select.sv
module ccu_cond_select
    import ccu_pkg::*;
(
    input  logic [COND_W-1:0]      cond_i,
    input  logic [NUM_GROUP-1:0]   terms_i,
    output verdict_t               verdict_o
);

    cond_group_e group_sel;
    logic        invert;
    logic        base;
    verdict_t    verdict_d;

    always_comb begin
        group_sel       = cond_group_e'(cond_i[COND_W-1:1]);
        base            = terms_i[group_sel];
        invert          = cond_i[0] & (group_sel != GRP_UNCOND);
        verdict_d.undef = (cond_i == {COND_W{1'b1}});
        verdict_d.pass  = (base ^ invert) & ~verdict_d.undef;
    end

    assign verdict_o = verdict_d;

    always_comb begin
        if (verdict_o.undef) assert (!verdict_o.pass)
            else $error("AST_UNDEF_NEVER_PASSES");  // R8
        if (cond_i == 4'b1110) assert (verdict_o.pass && !verdict_o.undef)
            else $error("AST_ALWAYS_PASSES");  // R7
    end

endmodule

// File: rtl/ccu_side_gate.sv
module ccu_side_gate #(
    parameter int NUM_REQ = 3
) (
    input  logic [NUM_REQ-1:0] req_i,
    input  logic               pass_i,
    output logic [NUM_REQ-1:0] gated_o
);

    for (genvar g = 0; g < NUM_REQ; g++) begin : g_gate
        assign gated_o[g] = req_i[g] & pass_i;
    end

endmodule

// File: rtl/ccu_eval_top.sv
module ccu_eval_top
    import ccu_pkg::*;
(
    input  logic [3:0] cond_i,
    input  logic       flag_n_i,
    input  logic       flag_z_i,
    input  logic       flag_c_i,
    input  logic       flag_v_i,
    input  logic       reg_we_i,
    input  logic       flag_we_i,
    input  logic       branch_req_i,
    output logic       pass_o,
    output logic       undef_o,
    output logic       reg_we_o,
    output logic       flag_we_o,
    output logic       branch_o
);

    status_flags_t        flags_d;
    logic [NUM_GROUP-1:0] terms;
    verdict_t             verdict;
    logic [NUM_SIDE-1:0]  side_req;
    logic [NUM_SIDE-1:0]  side_gated;

    always_comb begin
        flags_d.n = flag_n_i;
        flags_d.z = flag_z_i;
        flags_d.c = flag_c_i;
        flags_d.v = flag_v_i;
    end

    assign side_req = {branch_req_i, flag_we_i, reg_we_i};

    ccu_flag_terms u_terms (
        .flags_i (flags_d),
        .terms_o (terms)
    );

    ccu_cond_select u_select (
        .cond_i    (cond_i),
        .terms_i   (terms),
        .verdict_o (verdict)
    );

    ccu_side_gate #(.NUM_REQ(NUM_SIDE)) u_gate (
        .req_i   (side_req),
        .pass_i  (verdict.pass),
        .gated_o (side_gated)
    );

    assign pass_o    = verdict.pass;
    assign undef_o   = verdict.undef;
    assign reg_we_o  = side_gated[0];
    assign flag_we_o = side_gated[1];
    assign branch_o  = side_gated[2];

    always_comb begin
        if (!pass_o) assert (!reg_we_o && !flag_we_o && !branch_o)
            else $error("AST_FAIL_SQUASHES");  // R10
        if (pass_o) assert (reg_we_o == reg_we_i && flag_we_o == flag_we_i
                            && branch_o == branch_req_i)
            else $error("AST_PASS_FORWARDS");  // R9
        if (cond_i == 4'b0000) assert (pass_o == flag_z_i)
            else $error("AST_EQ_TRACKS_Z");  // R1
        if (cond_i == 4'b1011) assert (pass_o == (flag_n_i != flag_v_i))
            else $error("AST_LT_TRACKS_NV");  // R5
    end

endmodule

// File: tb/ccu_eval_top_tb.sv
`timescale 1ns/1ps
module ccu_eval_top_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] cond = 4'b0000;
    logic       fn = 1'b0, fz = 1'b0, fc = 1'b0, fv = 1'b0;
    logic       rwe = 1'b0, fwe = 1'b0, brq = 1'b0;
    logic       pass, undef, rwe_o, fwe_o, br_o;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    ccu_eval_top dut_i (
        .cond_i(cond), .flag_n_i(fn), .flag_z_i(fz), .flag_c_i(fc), .flag_v_i(fv),
        .reg_we_i(rwe), .flag_we_i(fwe), .branch_req_i(brq),
        .pass_o(pass), .undef_o(undef), .reg_we_o(rwe_o), .flag_we_o(fwe_o),
        .branch_o(br_o)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000 && !done) begin
            errors = errors + 1;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    function automatic logic ref_pass(input logic [3:0] c, input logic n, z, cy, v);
        case (c)
            4'd0:  return z;
            4'd1:  return !z;
            4'd2:  return cy;
            4'd3:  return !cy;
            4'd4:  return n;
            4'd5:  return !n;
            4'd6:  return v;
            4'd7:  return !v;
            4'd8:  return cy && !z;
            4'd9:  return !cy || z;
            4'd10: return n == v;
            4'd11: return n != v;
            4'd12: return !z && (n == v);
            4'd13: return z || (n != v);
            4'd14: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    task automatic check(input string req, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s cond=%b nzcv=%b%b%b%b actual=%b expected=%b",
                     req, what, cond, fn, fz, fc, fv, act, exp);
        end
    endtask

    task automatic apply(input logic [3:0] c, input logic [3:0] nzcv, input logic [2:0] req);
        @(negedge clk);
        cond = c;
        {fn, fz, fc, fv} = nzcv;
        {brq, fwe, rwe} = req;
        #1;
    endtask

    task automatic sweep(input string req, input logic [3:0] c);
        for (int f = 0; f < 16; f++) begin
            apply(c, 4'(f), 3'b111);
            check(req, "pass", pass, ref_pass(c, fn, fz, fc, fv));
        end
    endtask

    task automatic t_reset();
        @(negedge clk);
        #1;
        check("R1", "idle pass", pass, 1'b0);
        check("R8", "idle undef", undef, 1'b0);
        check("R10", "idle reg_we", rwe_o, 1'b0);
    endtask

    task automatic t_equal();     sweep("R1", 4'd0);  sweep("R1", 4'd1);  endtask
    task automatic t_carry();     sweep("R2", 4'd2);  sweep("R2", 4'd3);  endtask
    task automatic t_single();
        sweep("R3", 4'd4); sweep("R3", 4'd5); sweep("R3", 4'd6); sweep("R3", 4'd7);
    endtask
    task automatic t_unsigned();  sweep("R4", 4'd8);  sweep("R4", 4'd9);  endtask
    task automatic t_sge();       sweep("R5", 4'd10); sweep("R5", 4'd11); endtask
    task automatic t_sgt();       sweep("R6", 4'd12); sweep("R6", 4'd13); endtask

    task automatic t_always();
        for (int f = 0; f < 16; f++) begin
            apply(4'd14, 4'(f), 3'b000);
            check("R7", "pass", pass, 1'b1);
        end
    endtask

    task automatic t_undef();
        for (int c = 0; c < 16; c++) begin
            for (int f = 0; f < 16; f++) begin
                apply(4'(c), 4'(f), 3'b111);
                check("R8", "undef", undef, (c == 15));
                if (c == 15) begin
                    check("R8", "pass", pass, 1'b0);
                end
            end
        end
    endtask

    task automatic t_gate_pass();
        for (int r = 0; r < 8; r++) begin
            apply(4'd14, 4'b0000, 3'(r));
            check("R9", "reg_we", rwe_o, r[0]);
            check("R9", "flag_we", fwe_o, r[1]);
            check("R9", "branch", br_o, r[2]);
            apply(4'd0, 4'b0100, 3'(r));
            check("R9", "reg_we eq", rwe_o, r[0]);
            check("R9", "branch eq", br_o, r[2]);
        end
    endtask

    task automatic t_gate_fail();
        for (int r = 0; r < 8; r++) begin
            apply(4'd0, 4'b0000, 3'(r));
            check("R10", "reg_we", rwe_o, 1'b0);
            check("R10", "flag_we", fwe_o, 1'b0);
            check("R10", "branch", br_o, 1'b0);
            apply(4'd15, 4'b1111, 3'(r));
            check("R10", "undef reg_we", rwe_o, 1'b0);
            check("R10", "undef branch", br_o, 1'b0);
            apply(4'd12, 4'b1000, 3'(r));
            check("R10", "gt flag_we", fwe_o, 1'b0);
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        t_reset();
        t_equal();
        t_carry();
        t_single();
        t_unsigned();
        t_sge();
        t_sgt();
        t_always();
        t_undef();
        t_gate_pass();
        t_gate_fail();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule